// File: doc/BRIEF.md
# Sensor-Triggered Two-Road Intersection Controller

This block drives the lamps of an intersection where a major road crosses a minor road that carries a vehicle sensor. The major road keeps green until the sensor reports a waiting car. The minor road then gets green for a fixed interval, after which control goes back to the major road. A light-sequencing state machine decides which road has green. A separate timer state machine measures the minor-green interval. The two are linked only by a one-cycle start request and a one-cycle done pulse.

The sensor input is taken to be synchronous to the clock. The start request is combinational on the sensor (a Mealy output). The lamp signals depend only on the present state (Moore outputs). The present state, the start request and the done pulse are brought out on debug ports. Reset is asserted asynchronously and released through a two-stage synchronizer.

The `LIMIT` parameter sets the length of the interval. The counter counts from 0 up to `LIMIT`, so the minor road is green for `LIMIT`+1 cycles. The default of 255 gives an 8-bit count.

Top module: `xing_ctrl`

## Requirements
- R1: While reset is active, and afterwards until a car is reported, the outputs are major_go=1, minor_go=0, dbg_phase=0, dbg_start=0 and dbg_timeup=0. On dbg_phase, 0 means major-green and 1 means minor-green.
- R2: In major-green with car=0, the block stays in major-green at the next edge.
- R3: dbg_start is 1 in exactly those cycles where the block is in major-green and car=1, in the same cycle as car.
- R4: In major-green with car=1, the block is in minor-green after the next clock edge.
- R5: Minor-green lasts exactly `LIMIT`+1 cycles. The block is in major-green in the following cycle.
- R6: dbg_timeup is a single-cycle pulse. It occurs only in the last minor-green cycle.
- R7: car has no effect in minor-green. It raises no start request and does not lengthen the interval.
- R8: The lamp outputs are complementary Moore outputs: major_go = NOT dbg_phase and minor_go = dbg_phase.
- R9: A car that is present in the cycle right after minor-green ends starts a new interval at once. That interval is again the full `LIMIT`+1 cycles, because the count restarts from zero.
- R10: Asserting reset during minor-green returns the lamps to major-green without waiting for a clock. After release, a new request gets a full-length interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| car | input | 1 | Minor-road vehicle sensor, synchronous to clk |
| major_go | output | 1 | Major-road lamp, 1 = green, 0 = red |
| minor_go | output | 1 | Minor-road lamp, 1 = green, 0 = red |
| dbg_phase | output | 1 | Present light state, 0 = major-green, 1 = minor-green |
| dbg_start | output | 1 | Start request from the light FSM to the timer |
| dbg_timeup | output | 1 | Done pulse from the timer to the light FSM |

## Verification
A wrong light state shows on the lamps and on dbg_phase in the same cycle, because both are decoded directly from the state register. A timer that is off by one, or that does not clear between intervals, becomes visible only when minor-green ends. So each interval is measured to the exact cycle, including an interval that starts back-to-back with the previous one. A timer that restarts while minor-green is already running would show as a start pulse while dbg_phase=1, or as a longer green. The bench toggles the sensor through the whole minor phase to provoke exactly that.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic {
    PH_MAJOR = 1'b0,
    PH_MINOR = 1'b1
  } phase_t;

  typedef enum logic {
    TM_IDLE = 1'b0,
    TM_RUN  = 1'b1
  } tmr_state_t;

endpackage

// File: rtl/xing_rst_sync.sv
module xing_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/xing_timer.sv
module xing_timer
  import xing_pkg::*;
#(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic timeup_o
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT);

  tmr_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    timeup_o = 1'b0;
    unique case (state_q)
      TM_IDLE: begin
        cnt_d  = '0;
        cnt_en = (cnt_q != '0);
        if (start_i) begin
          state_d = TM_RUN;
        end
      end
      TM_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          timeup_o = 1'b1;
          cnt_d    = '0;
          state_d  = TM_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TM_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TM_RUN && !timeup_o) |=> (state_q == TM_RUN && cnt_q == $past(cnt_q) + CW'(1)));

  // R9
  run_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TM_IDLE && start_i) |=> (cnt_q == '0));

  // R6
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeup_o |=> (state_q == TM_IDLE));

endmodule

// File: rtl/xing_light_fsm.sv
module xing_light_fsm
  import xing_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic car_i,
  input  logic timeup_i,
  output logic start_o,
  output logic major_go_o,
  output logic minor_go_o,
  output logic phase_o
);

  phase_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    unique case (state_q)
      PH_MAJOR: begin
        if (car_i) begin
          start_o = 1'b1;
          state_d = PH_MINOR;
        end
      end
      PH_MINOR: begin
        if (timeup_i) begin
          state_d = PH_MAJOR;
        end
      end
      default: state_d = PH_MAJOR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_MAJOR;
    end else begin
      state_q <= state_d;
    end
  end

  assign major_go_o = (state_q == PH_MAJOR);
  assign minor_go_o = (state_q == PH_MINOR);
  assign phase_o    = state_q;

  // R2
  hold_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_MAJOR && !car_i) |=> (state_q == PH_MAJOR));

  // R4
  car_to_minor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_MAJOR && car_i) |=> (state_q == PH_MINOR));

  // R7
  hold_minor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_MINOR && !timeup_i) |=> (state_q == PH_MINOR));

endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl #(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car,
  output logic major_go,
  output logic minor_go,
  output logic dbg_phase,
  output logic dbg_start,
  output logic dbg_timeup
);

  logic rst_n_int;
  logic start_req;
  logic done_pulse;

  xing_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  xing_light_fsm u_light (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .car_i      (car),
    .timeup_i   (done_pulse),
    .start_o    (start_req),
    .major_go_o (major_go),
    .minor_go_o (minor_go),
    .phase_o    (dbg_phase)
  );

  xing_timer #(.LIMIT(LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_req),
    .timeup_o (done_pulse)
  );

  assign dbg_start  = start_req;
  assign dbg_timeup = done_pulse;

  // R6
  done_in_minor_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_pulse |-> minor_go);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_pulse |=> !done_pulse);

  // R8
  lamps_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones({major_go, minor_go}) == 1);

  // R7
  no_start_in_minor_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    minor_go |-> !start_req);

endmodule

// File: tb/xing_ctrl_tb.sv
`timescale 1ns/1ps
module xing_ctrl_tb;

  localparam int TB_LIMIT = 5;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic major_go, minor_go, dbg_phase, dbg_start, dbg_timeup;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xing_ctrl #(.LIMIT(TB_LIMIT)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .car        (car),
    .major_go   (major_go),
    .minor_go   (minor_go),
    .dbg_phase  (dbg_phase),
    .dbg_start  (dbg_start),
    .dbg_timeup (dbg_timeup)
  );

  // {car, expected phase, expected start, expected timeup}, one entry per cycle
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0_0_0_0,  // R2 idle major
    4'b0_0_0_0,  // R2
    4'b1_0_1_0,  // R3 request
    4'b0_1_0_0,  // R4 minor, count 0
    4'b1_1_0_0,  // R7 car ignored
    4'b0_1_0_0,
    4'b1_1_0_0,  // R7
    4'b0_1_0_0,
    4'b0_1_0_1,  // R5 R6 last minor cycle
    4'b0_0_0_0,  // R5 back to major
    4'b1_0_1_0,  // R3
    4'b1_1_0_0,  // R7 car held
    4'b1_1_0_0,
    4'b1_1_0_0,
    4'b1_1_0_0,
    4'b1_1_0_0,
    4'b1_1_0_1,  // R6
    4'b1_0_1_0,  // R9 immediate new request
    4'b0_1_0_0   // R9 minor again
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int len;
    int starts;
    int tups;
    // reset and release
    repeat (3) @(posedge clk);
    #1;
    chk(major_go == 1'b1 && minor_go == 1'b0, "R1", "lamps in reset", {major_go, minor_go}, 2);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(dbg_phase == 1'b0, "R1", "phase after reset", dbg_phase, 0);
    chk(dbg_start == 1'b0 && dbg_timeup == 1'b0, "R1", "handshake idle", {dbg_start, dbg_timeup}, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      car = VEC[i][3];
      #1;
      chk(dbg_phase == VEC[i][2], "R4", $sformatf("phase vec %0d", i), dbg_phase, VEC[i][2]);
      chk(major_go == !VEC[i][2] && minor_go == VEC[i][2], "R8",
          $sformatf("lamps vec %0d", i), {major_go, minor_go}, {!VEC[i][2], VEC[i][2]});
      chk(dbg_start == VEC[i][1], "R3", $sformatf("start vec %0d", i), dbg_start, VEC[i][1]);
      chk(dbg_timeup == VEC[i][0], "R6", $sformatf("timeup vec %0d", i), dbg_timeup, VEC[i][0]);
    end

    // let the last interval finish
    for (int k = 0; k < 20 && minor_go; k++) begin
      @(negedge clk);
      car = 1'b0;
      #1;
    end
    chk(major_go == 1'b1, "R5", "back to major", major_go, 1);

    // reset during minor-green
    @(negedge clk) car = 1'b1;
    @(negedge clk) car = 1'b0;
    @(negedge clk);
    #1;
    chk(minor_go == 1'b1, "R4", "minor before reset", minor_go, 1);
    rst_n = 1'b0;
    #1;
    chk(major_go == 1'b1 && dbg_phase == 1'b0, "R10", "async return to major",
        {major_go, dbg_phase}, 2);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(major_go == 1'b1 && dbg_timeup == 1'b0, "R1", "major after reset release",
        {major_go, dbg_timeup}, 2);

    // full interval after reset, sensor toggling throughout
    @(negedge clk) car = 1'b1;
    #1;
    chk(dbg_start == 1'b1, "R3", "start after reset", dbg_start, 1);
    len = 0;
    starts = 0;
    tups = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      car = k[0];
      #1;
      if (!minor_go) break;
      len++;
      if (dbg_start) starts++;
      if (dbg_timeup) tups++;
    end
    car = 1'b0;
    chk(len == TB_LIMIT + 1, "R10", "interval after reset", len, TB_LIMIT + 1);
    chk(len == TB_LIMIT + 1, "R5", "minor-green length", len, TB_LIMIT + 1);
    chk(starts == 0, "R7", "starts during minor", starts, 0);
    chk(tups == 1, "R6", "timeup pulses per interval", tups, 1);

    // quiet major holds
    repeat (4) @(negedge clk);
    #1;
    chk(major_go == 1'b1 && dbg_start == 1'b0, "R2", "major holds without car",
        {major_go, dbg_start}, 2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule